// File: doc/BRIEF.md
# Serial EEPROM Command Controller

This block is a serial-peripheral-bus slave (clock modes 0 and 3) placed in front of a 2048-byte array. A host selects it with an active-low chip select. The host then shifts in an 8-bit opcode, a 16-bit address when the command needs one, and any data bytes. Every field is sent MSB first. Input bits are taken on the rising serial clock, and the output bit changes on the falling serial clock. All pins are synchronised into the system clock. The serial clock must run at no more than a quarter of the system clock rate.

Writes are buffered and take effect only when chip select is released cleanly on a byte boundary. Writes to the array fill a 32-byte page buffer, which wraps inside its page. A self-timed busy period of `WR_CYCLES` system clocks then copies the buffer into the array. During that period the write-in-progress bit reads 1 and only the status read is obeyed. Reads stream from any address and wrap across the whole array.

An 8-bit status word holds several control bits: a write-protect enable, a software flag, a two-bit watchdog period select, a two-bit block-lock field, the write-enable latch and the busy bit. Block lock protects the upper quarter, the upper half or the whole array. The write-protect enable, together with an external protect pin, can freeze the status word. The watchdog select bits go out on a port. The flag set and clear commands also produce one-cycle pulses.

Top module: `spi_eeprom_ctrl`

## Requirements
- R1: After reset the status word reads 0x00, `wdt_sel` is 0 and `spi_miso_oe` is low whenever chip select has been high for the synchroniser delay.
- R2: Opcode 0x05 streams the status word, bit 7 to 0 = {WPEN, FLAG, WD1, WD0, BL1, BL0, WEL, BUSY}, and is obeyed while BUSY is 1.
- R3: Opcode 0x06 sets WEL (bit 1) only if chip select rises straight after its 8th bit; with any further clock the command is dropped. Opcode 0x04 clears WEL.
- R4: Opcode 0x03 followed by a 16-bit address streams bytes from that address with auto-increment, wrapping 0x7FF to 0x000. Address bits above bit 10 are ignored.
- R5: Opcode 0x02 commits only when WEL is 1 and chip select rises after a whole number (at least one) of data bytes; otherwise no busy period starts and the array is unchanged.
- R6: Data bytes of one write that run past the end of a 32-byte page wrap to the start of the same page.
- R7: A committed write holds BUSY (bit 0) at 1 for `WR_CYCLES` clocks. WEL is then cleared together with BUSY.
- R8: While BUSY is 1, every opcode other than 0x05 is ignored.
- R9: BL = bits 3:2: 00 locks nothing, 01 locks 0x600–0x7FF, 10 locks 0x400–0x7FF, 11 locks all. A write to a locked page starts no busy period. Locked bytes remain readable.
- R10: Opcode 0x01 with WEL set writes data bits 7 and 5:2 into the status word at the end of its busy period. Data bits 6, 1 and 0 are ignored. `wdt_sel` follows bits 5:4.
- R11: With WPEN = 1 and `wp_n` low, a status write is refused. A status write already committed completes even if `wp_n` falls afterwards.
- R12: Opcode 0x00 sets FLAG (bit 6) and pulses `flag_set_pulse`. Opcode 0x04 clears FLAG and pulses `flag_clr_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock (modes 0 and 3) |
| spi_mosi | input | 1 | Serial data in |
| wp_n | input | 1 | Write-protect pin, active low |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Output enable for `spi_miso` (high impedance when low) |
| wdt_sel | output | 2 | Watchdog period select from status bits 5:4 |
| flag_set_pulse | output | 1 | One-cycle pulse on a flag-set command |
| flag_clr_pulse | output | 1 | One-cycle pulse on a flag-clear command |

## Verification
A controller state that fails to return to idle when chip select rises shows up on the next command. The following status read then returns shifted or zero bits within 16 serial clocks. A wrong write-enable or busy bit is visible on the status read that follows the write. A wrong page pointer or lock decode stays hidden until the array is read back, so every write in the bench is followed by a read of the affected page. Dropped-command cases compare a status read and a read of the array against their values from before the command.

// File: rtl/spi_eep_pkg.sv
package spi_eep_pkg;

    localparam logic [7:0] OP_FLAG_SET = 8'h00;
    localparam logic [7:0] OP_STAT_WR  = 8'h01;
    localparam logic [7:0] OP_MEM_WR   = 8'h02;
    localparam logic [7:0] OP_MEM_RD   = 8'h03;
    localparam logic [7:0] OP_WE_CLR   = 8'h04;
    localparam logic [7:0] OP_STAT_RD  = 8'h05;
    localparam logic [7:0] OP_WE_SET   = 8'h06;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_RD_DATA,
        ST_WR_DATA,
        ST_SR_READ,
        ST_SR_DATA,
        ST_SR_HOLD,
        ST_CMD_HOLD,
        ST_DROP
    } ctl_state_e;

endpackage

// File: rtl/spi_eep_sync.sv
module spi_eep_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_i,
    input  logic sck_i,
    input  logic mosi_i,
    input  logic wp_n_i,
    output logic cs_n_o,
    output logic mosi_o,
    output logic wp_n_o,
    output logic sck_rise,
    output logic sck_fall
);
    // bit order: {wp_n, mosi, sck, cs_n}
    localparam logic [3:0] RST_VAL = 4'b1001;

    logic [3:0] pipe [STAGES];
    logic       sck_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
            sck_q <= 1'b0;
        end else begin
            pipe[0] <= {wp_n_i, mosi_i, sck_i, cs_n_i};
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
            sck_q <= pipe[STAGES-1][1];
        end
    end

    assign cs_n_o   = pipe[STAGES-1][0];
    assign mosi_o   = pipe[STAGES-1][2];
    assign wp_n_o   = pipe[STAGES-1][3];
    assign sck_rise =  pipe[STAGES-1][1] & ~sck_q;
    assign sck_fall = ~pipe[STAGES-1][1] &  sck_q;

endmodule

// File: rtl/spi_eep_mem.sv
module spi_eep_mem #(
    parameter int DEPTH = 2048,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
        rdata <= cells[raddr];
    end

endmodule

// File: rtl/spi_eep_prot.sv
module spi_eep_prot #(
    parameter int AW = 11
) (
    input  logic [1:0]    bl,
    input  logic [AW-1:0] addr,
    output logic          locked
);
    always_comb begin
        unique case (bl)
            2'b00: locked = 1'b0;
            2'b01: locked = (addr[AW-1:AW-2] == 2'b11);
            2'b10: locked = addr[AW-1];
            2'b11: locked = 1'b1;
        endcase
    end

endmodule

// File: rtl/spi_eeprom_ctrl.sv
module spi_eeprom_ctrl
    import spi_eep_pkg::*;
#(
    parameter int MEM_BYTES   = 2048,
    parameter int PAGE_BYTES  = 32,
    parameter int WR_CYCLES   = 400,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       spi_cs_n,
    input  logic       spi_sck,
    input  logic       spi_mosi,
    input  logic       wp_n,
    output logic       spi_miso,
    output logic       spi_miso_oe,
    output logic [1:0] wdt_sel,
    output logic       flag_set_pulse,
    output logic       flag_clr_pulse
);
    localparam int AW = $clog2(MEM_BYTES);
    localparam int PW = $clog2(PAGE_BYTES);
    localparam int CW = $clog2(WR_CYCLES + 1);

    // synchronised pins
    logic cs_n_s, mosi_s, wp_n_s, sck_rise, sck_fall;

    spi_eep_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .cs_n_i(spi_cs_n), .sck_i(spi_sck), .mosi_i(spi_mosi), .wp_n_i(wp_n),
        .cs_n_o(cs_n_s), .mosi_o(mosi_s), .wp_n_o(wp_n_s),
        .sck_rise(sck_rise), .sck_fall(sck_fall)
    );

    ctl_state_e state, state_nx;

    // shift path
    logic [2:0]    bit_cnt;
    logic [6:0]    in_sh;
    logic [7:0]    rx_byte;
    logic          byte_done;
    logic [7:0]    op_q;
    logic [7:0]    addr_hi;
    logic          addr_hi_seen;
    logic [15:0]   full_addr;
    logic [AW-1:0] addr_q;
    logic          miso_q;

    // status word fields
    logic       wpen, flb, wel, wip;
    logic [1:0] wd, bl;
    logic [7:0] status_v;

    // page buffer and busy engine
    logic [7:0]         pg_buf [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] pg_mask;
    logic               have_data;
    logic [CW-1:0]      busy_cnt;
    logic               busy_sr;
    logic [7:0]         sr_pend;
    logic [PW:0]        copy_idx;
    logic [AW-PW-1:0]   page_q;

    logic          mem_we;
    logic [AW-1:0] mem_waddr;
    logic [7:0]    mem_wdata, mem_rdata;
    logic          page_lock;

    logic cs_end, wr_go, sr_go, cmd_go;

    assign rx_byte   = {in_sh, mosi_s};
    assign byte_done = sck_rise && (bit_cnt == 3'd7) && !cs_n_s;
    assign full_addr = {addr_hi, rx_byte};
    assign status_v  = {wpen, flb, wd, bl, wel, wip};
    assign cs_end    = (state != ST_IDLE) && cs_n_s;

    spi_eep_prot #(.AW(AW)) u_prot (
        .bl(bl), .addr(addr_q), .locked(page_lock)
    );

    assign mem_we    = wip && !busy_sr && !copy_idx[PW] && pg_mask[copy_idx[PW-1:0]];
    assign mem_waddr = {page_q, copy_idx[PW-1:0]};
    assign mem_wdata = pg_buf[copy_idx[PW-1:0]];

    spi_eep_mem #(.DEPTH(MEM_BYTES), .AW(AW)) u_mem (
        .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .raddr(addr_q), .rdata(mem_rdata)
    );

    assign wr_go  = cs_end && (state == ST_WR_DATA) && (bit_cnt == 3'd0)
                    && have_data && wel && !page_lock && !wip;
    assign sr_go  = cs_end && (state == ST_SR_HOLD) && wel
                    && !(wpen && !wp_n_s) && !wip;
    assign cmd_go = cs_end && (state == ST_CMD_HOLD);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        if (state != ST_IDLE && cs_n_s) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:     if (!cs_n_s) state_nx = ST_OPCODE;
                ST_OPCODE: begin
                    if (byte_done) begin
                        if (wip && rx_byte != OP_STAT_RD) state_nx = ST_DROP;
                        else begin
                            case (rx_byte)
                                OP_MEM_RD, OP_MEM_WR:            state_nx = ST_ADDR;
                                OP_STAT_RD:                      state_nx = ST_SR_READ;
                                OP_STAT_WR:                      state_nx = ST_SR_DATA;
                                OP_WE_SET, OP_WE_CLR, OP_FLAG_SET: state_nx = ST_CMD_HOLD;
                                default:                         state_nx = ST_DROP;
                            endcase
                        end
                    end
                end
                ST_ADDR:     if (byte_done && addr_hi_seen)
                                 state_nx = (op_q == OP_MEM_RD) ? ST_RD_DATA : ST_WR_DATA;
                ST_SR_DATA:  if (byte_done) state_nx = ST_SR_HOLD;
                ST_SR_HOLD:  if (sck_rise) state_nx = ST_DROP;
                ST_CMD_HOLD: if (sck_rise) state_nx = ST_DROP;
                ST_RD_DATA, ST_WR_DATA, ST_SR_READ, ST_DROP: state_nx = state;
            endcase
        end
    end

    // datapath, status word and busy engine
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt        <= '0;
            in_sh          <= '0;
            op_q           <= '0;
            addr_hi        <= '0;
            addr_hi_seen   <= 1'b0;
            addr_q         <= '0;
            wpen           <= 1'b0;
            flb            <= 1'b0;
            wd             <= '0;
            bl             <= '0;
            wel            <= 1'b0;
            wip            <= 1'b0;
            pg_mask        <= '0;
            have_data      <= 1'b0;
            busy_cnt       <= '0;
            busy_sr        <= 1'b0;
            sr_pend        <= '0;
            copy_idx       <= '0;
            page_q         <= '0;
            flag_set_pulse <= 1'b0;
            flag_clr_pulse <= 1'b0;
        end else begin
            flag_set_pulse <= 1'b0;
            flag_clr_pulse <= 1'b0;

            if (state == ST_IDLE) begin
                bit_cnt      <= '0;
                addr_hi_seen <= 1'b0;
            end else if (sck_rise && !cs_n_s) begin
                in_sh   <= {in_sh[5:0], mosi_s};
                bit_cnt <= bit_cnt + 3'd1;
            end

            if (byte_done) begin
                unique case (state)
                    ST_OPCODE: begin
                        op_q <= rx_byte;
                        if (rx_byte == OP_MEM_WR) begin
                            pg_mask   <= '0;
                            have_data <= 1'b0;
                        end
                    end
                    ST_ADDR: begin
                        if (!addr_hi_seen) begin
                            addr_hi      <= rx_byte;
                            addr_hi_seen <= 1'b1;
                        end else begin
                            addr_q <= full_addr[AW-1:0];
                        end
                    end
                    ST_RD_DATA: addr_q <= addr_q + 1'b1;
                    ST_WR_DATA: begin
                        pg_mask[addr_q[PW-1:0]] <= 1'b1;
                        have_data               <= 1'b1;
                        addr_q[PW-1:0]          <= addr_q[PW-1:0] + 1'b1;
                    end
                    ST_SR_DATA: sr_pend <= rx_byte;
                    ST_IDLE, ST_SR_READ, ST_SR_HOLD, ST_CMD_HOLD, ST_DROP: ;
                endcase
            end

            if (cmd_go) begin
                case (op_q)
                    OP_WE_SET: wel <= 1'b1;
                    OP_WE_CLR: begin
                        wel            <= 1'b0;
                        flb            <= 1'b0;
                        flag_clr_pulse <= 1'b1;
                    end
                    OP_FLAG_SET: begin
                        flb            <= 1'b1;
                        flag_set_pulse <= 1'b1;
                    end
                    default: ;
                endcase
            end

            if (wr_go || sr_go) begin
                wip      <= 1'b1;
                busy_cnt <= CW'(WR_CYCLES);
                busy_sr  <= sr_go;
                copy_idx <= '0;
                page_q   <= addr_q[AW-1:PW];
            end else if (wip) begin
                if (!copy_idx[PW]) copy_idx <= copy_idx + 1'b1;
                if (busy_cnt == CW'(1)) begin
                    wip      <= 1'b0;
                    wel      <= 1'b0;
                    busy_cnt <= '0;
                    if (busy_sr) begin
                        wpen <= sr_pend[7];
                        wd   <= sr_pend[5:4];
                        bl   <= sr_pend[3:2];
                    end
                end else begin
                    busy_cnt <= busy_cnt - 1'b1;
                end
            end
        end
    end

    // page buffer storage (no reset needed: qualified by pg_mask)
    always_ff @(posedge clk) begin
        if (byte_done && state == ST_WR_DATA) pg_buf[addr_q[PW-1:0]] <= rx_byte;
    end

    // serial output, updated on falling serial clock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            miso_q <= 1'b0;
        end else if (sck_fall && !cs_n_s) begin
            unique case (state)
                ST_RD_DATA: miso_q <= mem_rdata[~bit_cnt];
                ST_SR_READ: miso_q <= status_v[~bit_cnt];
                ST_IDLE, ST_OPCODE, ST_ADDR, ST_WR_DATA, ST_SR_DATA,
                ST_SR_HOLD, ST_CMD_HOLD, ST_DROP: miso_q <= 1'b0;
            endcase
        end
    end

    assign spi_miso    = miso_q;
    assign spi_miso_oe = ~cs_n_s;
    assign wdt_sel     = wd;

endmodule

// File: rtl/spi_eeprom_ctrl_chk.sv
module spi_eeprom_ctrl_chk #(
    parameter int AW = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic          spi_cs_n,
    input logic          spi_miso_oe,
    input logic          cs_n_s,
    input logic [7:0]    status_v,
    input logic          mem_we,
    input logic [AW-1:0] mem_waddr,
    input logic          flag_set_pulse,
    input logic          flag_clr_pulse
);
    logic lock_hit;
    always_comb begin
        unique case (status_v[3:2])
            2'b00: lock_hit = 1'b0;
            2'b01: lock_hit = (mem_waddr >= AW'((3 << AW) / 4));
            2'b10: lock_hit = (mem_waddr >= AW'((1 << AW) / 2));
            2'b11: lock_hit = 1'b1;
        endcase
    end

    // R1
    oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3) |-> !spi_miso_oe);

    // R3
    wel_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_v[1]) |-> cs_n_s);

    // R5
    we_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> status_v[0]);

    // R7
    wel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status_v[0]) |-> !status_v[1]);

    // R9
    lock_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !lock_hit);

    // R10
    sr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_v[0] && $past(status_v[0]) |-> $stable({status_v[7], status_v[5:2]}));

    // R12
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flag_set_pulse, flag_clr_pulse}));

    // R12
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_set_pulse |-> status_v[6]);

endmodule

bind spi_eeprom_ctrl spi_eeprom_ctrl_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_miso_oe(spi_miso_oe),
    .cs_n_s(cs_n_s), .status_v(status_v), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .flag_set_pulse(flag_set_pulse), .flag_clr_pulse(flag_clr_pulse)
);

// File: tb/spi_eeprom_ctrl_bench.sv
module spi_eeprom_ctrl_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, wp_n = 1'b1;
    logic miso, miso_oe, fset, fclr;
    logic [1:0] wdt_sel;

    always #10 clk = ~clk;

    spi_eeprom_ctrl u_spi_eeprom_ctrl (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi),
        .wp_n(wp_n), .spi_miso(miso), .spi_miso_oe(miso_oe), .wdt_sel(wdt_sel),
        .flag_set_pulse(fset), .flag_clr_pulse(fclr)
    );

    int n_chk = 0, n_fail = 0;
    int set_cnt = 0, clr_cnt = 0;
    bit done = 0;
    bit m3 = 0;
    logic [7:0] ref_mem [2048];
    bit         known   [2048];
    logic [7:0] wbuf    [64];

    always @(posedge clk) begin
        if (fset) set_cnt++;
        if (fclr) clr_cnt++;
    end

    task automatic check8(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hp();
        repeat (5) @(negedge clk);
    endtask

    task automatic cs_lo();
        @(negedge clk);
        sck  = m3;
        cs_n = 1'b0;
        hp();
    endtask

    task automatic cs_hi();
        hp();
        cs_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 0; i < 8; i++) begin
            if (m3) sck = 1'b0;
            mosi = tx[7-i];
            hp();
            rx[7-i] = miso;
            sck = 1'b1;
            hp();
            if (!m3) sck = 1'b0;
        end
    endtask

    task automatic cmd(input logic [7:0] op);
        logic [7:0] d;
        cs_lo(); xfer(op, d); cs_hi();
    endtask

    task automatic rdsr(output logic [7:0] s);
        logic [7:0] d;
        cs_lo(); xfer(8'h05, d); xfer(8'h00, s); cs_hi();
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        for (int k = 0; k < 40; k++) begin
            rdsr(s);
            if (!s[0]) break;
        end
    endtask

    task automatic wr(input logic [15:0] a, input int n, input int extra, input bit commit);
        logic [7:0] d;
        logic [10:0] x;
        cs_lo();
        xfer(8'h02, d); xfer(a[15:8], d); xfer(a[7:0], d);
        for (int i = 0; i < n; i++) xfer(wbuf[i], d);
        for (int i = 0; i < extra; i++) begin
            if (m3) sck = 1'b0;
            hp(); sck = 1'b1; hp();
            if (!m3) sck = 1'b0;
        end
        cs_hi();
        if (commit) begin
            for (int i = 0; i < n; i++) begin
                x = {a[10:5], 5'(a[4:0] + 5'(i))};
                ref_mem[x] = wbuf[i];
                known[x]   = 1'b1;
            end
        end
    endtask

    task automatic rd_chk(input logic [15:0] a, input int n, input string req);
        logic [7:0] d;
        logic [10:0] x;
        cs_lo();
        xfer(8'h03, d); xfer(a[15:8], d); xfer(a[7:0], d);
        for (int i = 0; i < n; i++) begin
            xfer(8'h00, d);
            x = 11'(a[10:0] + 11'(i));
            if (known[x]) check8(req, d, ref_mem[x]);
        end
        cs_hi();
    endtask

    task automatic wr1(input logic [15:0] a, input logic [7:0] v, input bit commit);
        cmd(8'h06);
        wbuf[0] = v;
        wr(a, 1, 0, commit);
        if (commit) wait_idle();
    endtask

    task automatic wrsr(input logic [7:0] v);
        logic [7:0] d;
        cs_lo(); xfer(8'h01, d); xfer(v, d); cs_hi();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [7:0] s;
        int seed;
        int sc;
        for (int i = 0; i < 2048; i++) known[i] = 1'b0;
        seed = $urandom(32'd1234);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1 reset state
        check8("R1 oe", {7'd0, miso_oe}, 8'h00);
        check8("R1 wdt_sel", {6'd0, wdt_sel}, 8'h00);
        rdsr(s); check8("R1 status", s, 8'h00);

        // R3 WREN followed by extra byte is dropped, then clean WREN, WRDI
        cs_lo(); xfer(8'h06, s); xfer(8'h00, s); cs_hi();
        rdsr(s); check8("R3 wren extra clocks", s, 8'h00);
        cmd(8'h06); rdsr(s); check8("R3 wren", s, 8'h02);
        cmd(8'h04); rdsr(s); check8("R3 wrdi", s, 8'h00);

        // R5/R7/R8/R2 committed write, busy behaviour
        cmd(8'h06);
        wbuf[0] = 8'hAA; wbuf[1] = 8'hBB;
        wr(16'h0010, 2, 0, 1);
        cmd(8'h00);
        rdsr(s); check8("R2 status read while busy", s, 8'h03);
        wait_idle();
        rdsr(s); check8("R7 wel cleared after busy / R8 flag cmd ignored", s, 8'h00);
        check8("R8 no flag pulse while busy", 8'(set_cnt), 8'h00);
        rd_chk(16'h0010, 2, "R5 readback");

        // R5 aborts
        cmd(8'h06);
        wbuf[0] = 8'hCC;
        wr(16'h0010, 1, 4, 0);
        rdsr(s); check8("R5 off-boundary abort", s, 8'h02);
        wr(16'h0010, 0, 0, 0);
        rdsr(s); check8("R5 no data byte abort", s, 8'h02);
        cmd(8'h04);
        wr(16'h0010, 1, 0, 0);
        rdsr(s); check8("R5 no wel", s, 8'h00);
        rd_chk(16'h0010, 1, "R5 array unchanged");

        // R6 page wrap
        cmd(8'h06);
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
        wr(16'h003E, 4, 0, 1); wait_idle();
        rd_chk(16'h003E, 2, "R6 page end");
        rd_chk(16'h0020, 2, "R6 page wrap");

        // R4 read wrap across array, upper address bits ignored
        cmd(8'h06); wbuf[0] = 8'hE1; wbuf[1] = 8'hE2;
        wr(16'h07FE, 2, 0, 1); wait_idle();
        cmd(8'h06); wbuf[0] = 8'h01; wbuf[1] = 8'h02;
        wr(16'h0000, 2, 0, 1); wait_idle();
        rd_chk(16'hF7FE, 4, "R4 read wrap");
        wr1(16'h0400, 8'h40, 1);
        wr1(16'h0600, 8'h60, 1);

        // R10 status write
        cmd(8'h06); wrsr(8'hFF); wait_idle();
        rdsr(s); check8("R10 status write", s, 8'hBC);
        check8("R10 wdt_sel", {6'd0, wdt_sel}, 8'h03);

        // R9 full lock
        wr1(16'h0010, 8'h5A, 0);
        rdsr(s); check8("R9 locked write no busy", s, 8'hBE);
        rd_chk(16'h0010, 1, "R9 locked readable");

        // R11 protect pin
        wp_n = 1'b0;
        wrsr(8'h00);
        rdsr(s); check8("R11 refused", s, 8'hBE);
        wp_n = 1'b1;
        wrsr(8'h84);
        wp_n = 1'b0;
        wait_idle();
        rdsr(s); check8("R11 completes after pin drop", s, 8'h84);
        wp_n = 1'b1;

        // R9 half lock
        cmd(8'h06); wrsr(8'h08); wait_idle();
        rdsr(s); check8("R9 bl=10", s, 8'h08);
        wr1(16'h03F0, 8'h77, 1);
        wr1(16'h0400, 8'h66, 0);
        rdsr(s); check8("R9 half lock no busy", s, 8'h0A);
        rd_chk(16'h03F0, 1, "R9 lower half writable");
        rd_chk(16'h0400, 1, "R9 upper half locked");

        // R9 quarter lock
        wrsr(8'h04); wait_idle();
        wr1(16'h05F0, 8'h55, 1);
        wr1(16'h0600, 8'h99, 0);
        rd_chk(16'h05F0, 1, "R9 below quarter writable");
        rd_chk(16'h0600, 1, "R9 top quarter locked");

        // R10 ignored bits, wdt select
        wrsr(8'h53); wait_idle();
        rdsr(s); check8("R10 bits 6,1,0 ignored", s, 8'h10);
        check8("R10 wdt_sel=01", {6'd0, wdt_sel}, 8'h01);
        cmd(8'h06); wrsr(8'h00); wait_idle();

        // R12 flag
        sc = set_cnt;
        cmd(8'h00); rdsr(s); check8("R12 flag set", s, 8'h40);
        check8("R12 set pulse", 8'(set_cnt - sc), 8'h01);
        sc = clr_cnt;
        cmd(8'h04); rdsr(s); check8("R12 flag clear", s, 8'h00);
        check8("R12 clr pulse", 8'(clr_cnt - sc), 8'h01);

        // random writes and reads, both clock modes (R4 R5 R6)
        for (int it = 0; it < 9; it++) begin
            logic [15:0] a;
            int n;
            m3 = 1'($urandom() & 1);
            a  = 16'($urandom() & 16'h07FF);
            n  = 1 + int'($urandom() % 36);
            for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom());
            cmd(8'h06);
            wr(a, n, 0, 1);
            wait_idle();
            rd_chk({5'd0, a[10:5], 5'd0}, 32, "R6 random page readback");
        end
        m3 = 0;
        finish_run();
    end

endmodule